// File: doc/BRIEF.md
# Direct-Mapped Write-Back Data Cache

This block is a data cache for a 32-bit processor with byte addresses. It holds 1024 lines of one 32-bit word each and uses direct mapping. Each line has a valid flag, a dirty flag, a stored tag and a data word. A request on the processor side is looked up in the same cycle it is issued. A hit completes without any memory traffic. Loads return the line's word, and stores change only the line and mark it dirty.

On a miss the controller checks the victim line. If the victim is valid and dirty, it first writes the victim's word back to memory, at the address rebuilt from the victim's stored tag and the current index. It then reads the wanted word and installs it as a clean line. After that it goes back to the lookup step, where the access now hits and completes. A store miss is handled the same way: the fetched word is installed first, and the store then lands on it as an ordinary store hit. Depending on the victim, a miss costs no write and one read, or one write followed by one read.

The processor holds its request stable until it sees ready high at a clock edge. The memory side holds each single-word request stable until it receives a one-cycle acknowledge.

Top module: `dmc_top`

## Requirements
- R1: An address is split into a tag in bits [31:12] and a line index in bits [11:2]. Bits [1:0] take no part in the lookup, so two addresses that differ only in those bits reach the same word.
- R2: While reset is held and just after it, `cpu_ready` and `mem_req` are low. Reset clears every valid and dirty flag, so no access after reset causes a write-back.
- R3: A line whose valid flag is clear always misses, even when its stored tag equals the address tag. The first access to address 0 after reset takes one memory read.
- R4: A load hit raises `cpu_ready` in the cycle the request is presented, returns the line's word on `cpu_rdata`, and makes no memory request.
- R5: A store hit updates only the cached word and sets the line's dirty flag. It makes no memory request, and later loads of that address return the stored value.
- R6: A store miss first reads the word from memory, then writes the store data into the line. The line ends up dirty, so its later eviction writes the store data back.
- R7: A miss whose victim is invalid or clean makes exactly one memory read (`mem_we` = 0) and no memory write.
- R8: A miss whose victim is valid and dirty first writes the victim's word to memory at address {stored tag, index, 2'b00} (`mem_we` = 1). It then reads the new word.
- R9: Filling a line leaves it valid and clean, so evicting a line that was only loaded causes no write-back.
- R10: `cpu_ready` stays low from miss detection until the access completes. With a memory that acknowledges one cycle after a request, a hit completes in 1 cycle, a clean miss in 4 and a dirty miss in 6.
- R11: Once raised, `mem_req` stays high with `mem_addr`, `mem_we` and `mem_wdata` unchanged until the cycle `mem_ack` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset, synchronous |
| cpu_req | input | 1 | Processor access request, held until ready |
| cpu_we | input | 1 | 1 for store, 0 for load |
| cpu_addr | input | 32 | Byte address of the access |
| cpu_wdata | input | 32 | Store data |
| cpu_rdata | output | 32 | Load data, valid while cpu_ready is high |
| cpu_ready | output | 1 | Access completes at this clock edge |
| mem_req | output | 1 | Memory transaction request |
| mem_we | output | 1 | 1 for write-back, 0 for fill read |
| mem_addr | output | 32 | Word-aligned memory address |
| mem_wdata | output | 32 | Write-back data |
| mem_rdata | input | 32 | Fill data, valid with mem_ack |
| mem_ack | input | 1 | One-cycle acknowledge ending a transaction |

## Verification
The bench first touches address 0 straight after reset, where the stored tag is zero and only the valid flag can produce the miss. A design that ignored the valid flag would return stale data there without reading memory. It then dirties a line and evicts it with a conflicting tag. A design that took the write-back address from the new tag would write to the wrong word, and one that skipped the write-back would lose the store, which shows up when the old address is loaded again. Evicting a line that was only filled checks that a fill clears the dirty flag, since a design that kept the flag would cause a spurious write. A store miss and the index 1023 / all-ones tag boundary are covered too, followed by a pseudo-random sweep over a few conflicting tags. In every access the bench checks the latency and the exact number of memory reads and writes.

// File: rtl/dmc_pkg.sv
package dmc_pkg;
  typedef enum logic [1:0] {
    ST_CMP  = 2'd0,
    ST_WB   = 2'd1,
    ST_FILL = 2'd2
  } dmc_state_e;
endpackage

// File: rtl/dmc_tag_store.sv
module dmc_tag_store #(
  parameter int unsigned TAG_W = 20,
  parameter int unsigned IDX_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_valid,
  output logic             rd_dirty,
  output logic [TAG_W-1:0] rd_tag,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic             wr_dirty
);
  localparam int unsigned LINES = 1 << IDX_W;

  logic [LINES-1:0] valid_q;
  logic [LINES-1:0] dirty_q;
  logic [TAG_W-1:0] tag_mem [LINES];

  // flags live in flops so reset can clear them all at once
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else if (wr_en) begin
      valid_q[wr_idx] <= 1'b1;
      dirty_q[wr_idx] <= wr_dirty;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) tag_mem[wr_idx] <= wr_tag;
  end

  assign rd_valid = valid_q[rd_idx];
  assign rd_dirty = dirty_q[rd_idx];
  assign rd_tag   = tag_mem[rd_idx];
endmodule

// File: rtl/dmc_data_store.sv
module dmc_data_store #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned IDX_W  = 10
) (
  input  logic              clk,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data
);
  localparam int unsigned LINES = 1 << IDX_W;

  logic [DATA_W-1:0] data_mem [LINES];

  always_ff @(posedge clk) begin
    if (wr_en) data_mem[wr_idx] <= wr_data;
  end

  assign rd_data = data_mem[rd_idx];
endmodule

// File: rtl/dmc_ctrl.sv
module dmc_ctrl
  import dmc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cpu_req,
  input  logic cpu_we,
  input  logic hit,
  input  logic victim_dirty,
  input  logic mem_ack,
  output logic cpu_ready,
  output logic mem_req,
  output logic mem_we,
  output logic wb_phase,
  output logic fill_evt,
  output logic store_hit_evt,
  output logic miss_evt
);
  dmc_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_CMP:  if (cpu_req && !hit) st_d = victim_dirty ? ST_WB : ST_FILL;
      ST_WB:   if (mem_ack) st_d = ST_FILL;
      ST_FILL: if (mem_ack) st_d = ST_CMP;   // back to compare, which now hits
      default: st_d = ST_CMP;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= ST_CMP;
    else        st_q <= st_d;
  end

  assign cpu_ready     = (st_q == ST_CMP) && cpu_req && hit;
  assign miss_evt      = (st_q == ST_CMP) && cpu_req && !hit;
  assign store_hit_evt = cpu_ready && cpu_we;
  assign mem_req       = (st_q != ST_CMP);
  assign mem_we        = (st_q == ST_WB);
  assign wb_phase      = (st_q == ST_WB);
  assign fill_evt      = (st_q == ST_FILL) && mem_ack;

  // R4
  ready_no_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |-> !mem_req);

  // R8
  dirty_wb_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_evt && victim_dirty) |=> (mem_req && mem_we));

  // R7
  clean_fill_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_evt && !victim_dirty) |=> (mem_req && !mem_we));

  // R8
  wb_then_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && mem_ack) |=> (mem_req && !mem_we));
endmodule

// File: rtl/dmc_top.sv
module dmc_top #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned IDX_W  = 10,
  parameter int unsigned OFF_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              cpu_ready,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_ack
);
  localparam int unsigned TAG_W = ADDR_W - IDX_W - OFF_W;

  function automatic logic [TAG_W-1:0] addr_tag(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1 -: TAG_W];
  endfunction

  function automatic logic [IDX_W-1:0] addr_idx(input logic [ADDR_W-1:0] a);
    return a[OFF_W +: IDX_W];
  endfunction

  function automatic logic [ADDR_W-1:0] join_addr(input logic [TAG_W-1:0] t,
                                                  input logic [IDX_W-1:0] i);
    return {t, i, {OFF_W{1'b0}}};
  endfunction

  logic [TAG_W-1:0]  a_tag;
  logic [IDX_W-1:0]  a_idx;
  logic              unused_off_bits;
  logic              l_valid, l_dirty;
  logic [TAG_W-1:0]  l_tag;
  logic [DATA_W-1:0] l_data;
  logic              hit, victim_dirty;
  logic              wb_phase, fill_evt, store_hit_evt, miss_evt;
  logic              line_wr;

  assign a_tag           = addr_tag(cpu_addr);
  assign a_idx           = addr_idx(cpu_addr);
  assign unused_off_bits = ^cpu_addr[OFF_W-1:0];

  assign hit          = l_valid && (l_tag == a_tag);
  assign victim_dirty = l_valid && l_dirty;
  assign line_wr      = fill_evt || store_hit_evt;

  dmc_tag_store #(.TAG_W(TAG_W), .IDX_W(IDX_W)) i_tags (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_idx   (a_idx),
    .rd_valid (l_valid),
    .rd_dirty (l_dirty),
    .rd_tag   (l_tag),
    .wr_en    (line_wr),
    .wr_idx   (a_idx),
    .wr_tag   (a_tag),
    .wr_dirty (store_hit_evt)
  );

  dmc_data_store #(.DATA_W(DATA_W), .IDX_W(IDX_W)) i_data (
    .clk     (clk),
    .rd_idx  (a_idx),
    .rd_data (l_data),
    .wr_en   (line_wr),
    .wr_idx  (a_idx),
    .wr_data (fill_evt ? mem_rdata : cpu_wdata)
  );

  dmc_ctrl i_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .cpu_req       (cpu_req),
    .cpu_we        (cpu_we),
    .hit           (hit),
    .victim_dirty  (victim_dirty),
    .mem_ack       (mem_ack),
    .cpu_ready     (cpu_ready),
    .mem_req       (mem_req),
    .mem_we        (mem_we),
    .wb_phase      (wb_phase),
    .fill_evt      (fill_evt),
    .store_hit_evt (store_hit_evt),
    .miss_evt      (miss_evt)
  );

  // write-back address comes from the victim's stored tag
  assign mem_addr  = wb_phase ? join_addr(l_tag, a_idx) : join_addr(a_tag, a_idx);
  assign mem_wdata = l_data;
  assign cpu_rdata = l_data;

  // R9
  fill_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_evt |=> (l_valid && !l_dirty && l_tag == $past(a_tag)));

  // R5
  store_sets_dirty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (store_hit_evt && cpu_req && $stable(cpu_addr)) |=> (!cpu_req || l_dirty || $changed(cpu_addr)));

  // R11
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));
endmodule

// File: tb/test_dmc_top.sv
module test_dmc_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_req = 1'b0, cpu_we = 1'b0;
  logic [31:0] cpu_addr = '0, cpu_wdata = '0;
  logic [31:0] cpu_rdata;
  logic        cpu_ready;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic [31:0] mem_rdata = '0;
  logic        mem_ack = 1'b0;

  always #5 clk = ~clk;

  dmc_top i_dmc_top (
    .clk(clk), .rst_n(rst_n),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ack(mem_ack)
  );

  int checks = 0, errors = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] init_word(input logic [31:0] w);
    return (w * 32'h9E37_79B1) ^ 32'h0BAD_F00D;
  endfunction

  // memory model: ack one cycle after request
  logic [31:0] mem_arr [logic [31:0]];
  int          rd_cnt = 0, wr_cnt = 0, hold_err = 0;
  logic [31:0] last_wr_addr = '0, last_wr_data = '0;
  bit          pend = 1'b0;
  logic [31:0] pend_addr = '0;

  always @(posedge clk) begin
    if (!rst_n) begin
      mem_ack <= 1'b0;
      pend = 1'b0;
    end else begin
      if (pend && (!mem_req || mem_addr != pend_addr)) hold_err++;
      pend = mem_req && !mem_ack && !pend;
      pend_addr = mem_addr;
      if (mem_ack) mem_ack <= 1'b0;
      else if (mem_req) begin
        mem_ack <= 1'b1;
        if (mem_we) begin
          mem_arr[mem_addr >> 2] = mem_wdata;
          wr_cnt++;
          last_wr_addr = mem_addr;
          last_wr_data = mem_wdata;
        end else begin
          mem_rdata <= mem_arr.exists(mem_addr >> 2) ? mem_arr[mem_addr >> 2]
                                                     : init_word(mem_addr >> 2);
          rd_cnt++;
        end
      end
    end
  end

  // reference state computed from the requirements
  logic [31:0] ref_mem [logic [31:0]];
  bit          sh_v [int];
  bit          sh_d [int];
  logic [19:0] sh_t [int];

  function automatic logic [31:0] ref_get(input logic [31:0] w);
    return ref_mem.exists(w) ? ref_mem[w] : init_word(w);
  endfunction

  typedef struct { bit is_load; logic [31:0] data; string req; } exp_t;
  exp_t exp_q[$];

  // monitor: pops one expected item per completed access
  always @(negedge clk) begin
    if (rst_n && cpu_req && cpu_ready) begin
      if (exp_q.size() == 0) check(1'b0, "R4", "unexpected completion", cpu_rdata, '0);
      else begin
        exp_t e;
        e = exp_q.pop_front();
        if (e.is_load) check(cpu_rdata === e.data, e.req, "load data", cpu_rdata, e.data);
      end
    end
  end

  task automatic access(input bit we, input logic [31:0] addr,
                        input logic [31:0] wdata, input string req);
    int idx;
    logic [19:0] tg;
    bit hit, exp_wb;
    logic [31:0] wb_addr, wb_data;
    int exp_cyc, cyc, rd0, wr0;
    exp_t e;
    idx = int'(addr[11:2]);
    tg  = addr[31:12];
    hit = sh_v.exists(idx) && sh_v[idx] && sh_t[idx] == tg;
    exp_wb = 1'b0;
    wb_addr = '0;
    wb_data = '0;
    if (!hit) begin
      if (sh_v.exists(idx) && sh_v[idx] && sh_d[idx]) begin
        exp_wb  = 1'b1;
        wb_addr = {sh_t[idx], addr[11:2], 2'b00};
        wb_data = ref_get(wb_addr >> 2);
      end
      sh_v[idx] = 1'b1; sh_t[idx] = tg; sh_d[idx] = 1'b0;
    end
    if (we) begin
      sh_d[idx] = 1'b1;
      ref_mem[addr >> 2] = wdata;
    end
    exp_cyc = hit ? 1 : (exp_wb ? 6 : 4);
    e.is_load = !we; e.data = ref_get(addr >> 2); e.req = req;
    exp_q.push_back(e);
    rd0 = rd_cnt; wr0 = wr_cnt;
    cpu_req = 1'b1; cpu_we = we; cpu_addr = addr; cpu_wdata = wdata;
    cyc = 0;
    do begin
      @(negedge clk);
      cyc++;
    end while (!cpu_ready);
    @(posedge clk);
    #1;
    cpu_req = 1'b0;
    check(cyc == exp_cyc, "R10", {req, " latency"}, cyc, exp_cyc);
    check(rd_cnt - rd0 == (hit ? 0 : 1), hit ? "R4" : "R7", {req, " memory reads"},
          rd_cnt - rd0, hit ? 0 : 1);
    check(wr_cnt - wr0 == (exp_wb ? 1 : 0), exp_wb ? "R8" : "R9", {req, " memory writes"},
          wr_cnt - wr0, exp_wb ? 1 : 0);
    if (exp_wb) begin
      check(last_wr_addr == wb_addr, "R8", "write-back address", last_wr_addr, wb_addr);
      check(last_wr_data == wb_data, "R8", "write-back data", last_wr_data, wb_data);
    end
  endtask

  task automatic finish_sim();
    check(hold_err == 0, "R11", "memory request held until ack", hold_err, 0);
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(10 * 200000);
    check(1'b0, "R10", "watchdog expired", '0, '0);
    finish_sim();
  end

  initial begin
    logic [15:0] lfsr;
    repeat (3) @(posedge clk);
    #1;
    check(cpu_ready == 1'b0 && mem_req == 1'b0, "R2", "outputs in reset",
          {cpu_ready, mem_req}, '0);
    rst_n = 1'b1;
    @(negedge clk);
    check(mem_req == 1'b0, "R2", "mem_req idle after reset", mem_req, 0);
    @(posedge clk); #1;

    access(0, 32'h0000_0000, '0, "R3");           // invalid line with zero tag
    access(0, 32'h0000_0002, '0, "R1");           // offset bits ignored
    access(1, 32'h0000_0000, 32'hDEAD_BEEF, "R5"); // store hit, no traffic
    access(0, 32'h0000_0001, '0, "R5");
    access(0, 32'h0000_1000, '0, "R8");           // dirty victim written back
    access(0, 32'h0000_0000, '0, "R9");           // clean victim, data from memory
    access(1, 32'h0000_2004, 32'h1234_5678, "R6"); // store miss
    access(0, 32'h0000_2004, '0, "R6");
    access(0, 32'h0000_3004, '0, "R6");           // evicts the merged store
    access(0, 32'h0000_2004, '0, "R6");
    access(0, 32'h0000_0FFC, '0, "R1");           // last index
    access(1, 32'hFFFF_FFFC, 32'h0F0F_0F0F, "R1"); // all-ones tag, last index
    access(0, 32'h0000_0FFC, '0, "R8");
    access(0, 32'hFFFF_FFFC, '0, "R1");

    lfsr = 16'hACE1;
    for (int n = 0; n < 80; n++) begin
      logic [31:0] a;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      a = {18'h0, lfsr[1:0], 7'h0, lfsr[4:2], 2'b00};
      access(lfsr[5], a, {lfsr, ~lfsr}, "R7");
    end
    repeat (2) @(posedge clk);
    check(exp_q.size() == 0, "R10", "all accesses completed", exp_q.size(), 0);
    finish_sim();
  end
endmodule